// File: doc/BRIEF.md
# Prefix-Selected Command Bus Execution Unit

This unit is one of several execution resources that sit on a shared 16-bit command bus. A central sequencer shows one microinstruction per micro cycle on the bus. Every attached unit watches the leading bits of each word for its own identifier. Identifiers are prefix-free codes of varying length, so at most one unit can claim any word. A unit that needs a wide control field is given a short identifier, which leaves more of the word for control bits.

When the identifier matches and the unit is idle, the word is captured at the next clock edge. The unit then runs its operation while the sequencer goes on issuing further words. The run time comes from the captured word, so it is data-dependent. At completion the unit raises a one-cycle completion pulse and sets its completion flag bit. The sequencer can poll that bit to synchronise. While the unit is busy it takes no new word. A sequencer that wants this unit must hold its word on the bus until the busy output falls.

The datapath is an accumulator of `DATA_W` bits with four operations: load, add, shift and xor. The identifier value, identifier length, field widths and the shift variant (zero fill or rotate) are all parameters.

Top module: `prefix_exec_unit`

## Requirements
- R1: After reset, `busy`, `done_pulse` and `flag_bit` are 0 and `acc_out` is 0.
- R2: A word is accepted only when `cmd_valid` is 1, its top `ID_LEN` bits equal `ID_CODE` (default `01`), and `busy` is 0. Any other word is ignored: `busy`, `flag_bit` and `acc_out` keep their values.
- R3: In the cycle after an accept, `busy` is 1 and `flag_bit` is 0.
- R4: The control word is the instruction bits below the identifier, right-aligned. With the defaults: bits [7:0] are the immediate, bits [11:8] are the extra latency L, and bits [13:12] are the operation. Operation 0 loads the immediate. Operation 1 adds the immediate modulo 2^8. Operation 2 shifts the accumulator left by imm[2:0] with zero fill. Operation 3 xors the immediate into the accumulator.
- R5: After an accept with latency L, `busy` stays 1 for L+1 cycles. The operation completes at the (L+1)-th clock edge after the accept edge.
- R6: At completion `acc_out` takes the new value, `busy` falls, and `done_pulse` is 1 for exactly one cycle. `flag_bit` becomes 1 and stays 1 until the next accept.
- R7: A matching word that appears while `busy` is 1 is not latched. If it is held on the bus, it is accepted at the first edge after `busy` has fallen. Its result then follows the earlier operation's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Bus word valid this cycle |
| cmd_data | input | 16 | Microinstruction on the command bus |
| busy | output | 1 | Operation in progress; new words are refused |
| done_pulse | output | 1 | One-cycle completion strobe |
| flag_bit | output | 1 | Completion flag, cleared on accept |
| acc_out | output | 8 | Accumulator value |

## Verification
The hardest case to reach is a matching word that arrives while the unit is still running and is then held until it is taken. The bench starts an operation with a long latency and at once puts a second matching word on the bus with valid held. It checks three things. The second word is refused on the finishing edge. It is taken on the very next edge. The first result is visible before the second result replaces it. Foreign identifiers that share a leading bit with the unit's code are also applied, to show that only the full prefix matches.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
   typedef enum logic [1:0] {
      OP_LOAD = 2'd0,
      OP_ADD  = 2'd1,
      OP_SHL  = 2'd2,
      OP_XOR  = 2'd3
   } pxu_op_e;
   localparam int OP_W = 2;
endpackage

// File: rtl/pxu_prefix_match.sv
module pxu_prefix_match #(
   parameter int          BUS_W   = 16,
   parameter int          ID_LEN  = 2,
   parameter int unsigned ID_CODE = 1,
   localparam int         CTRL_W  = BUS_W - ID_LEN
) (
   input  logic              cmd_valid,
   input  logic [BUS_W-1:0]  cmd_data,
   output logic              id_hit,
   output logic [CTRL_W-1:0] ctrl_word
);
   localparam logic [ID_LEN-1:0] ID_BITS = ID_LEN'(ID_CODE);

   generate
      if (ID_LEN == 1) begin : g_single
         assign id_hit = cmd_valid && (cmd_data[BUS_W-1] == ID_BITS[0]);
      end else begin : g_multi
         assign id_hit = cmd_valid && (cmd_data[BUS_W-1 -: ID_LEN] == ID_BITS);
      end
   endgenerate

   assign ctrl_word = cmd_data[CTRL_W-1:0];
endmodule

// File: rtl/pxu_ctrl_reg.sv
module pxu_ctrl_reg
   import pxu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  pxu_op_e           op_in,
   input  logic [DATA_W-1:0] imm_in,
   output pxu_op_e           op_q,
   output logic [DATA_W-1:0] imm_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q  <= OP_LOAD;
         imm_q <= '0;
      end else if (load) begin
         op_q  <= op_in;
         imm_q <= imm_in;
      end
   end
endmodule

// File: rtl/pxu_latency_timer.sv
module pxu_latency_timer #(
   parameter int LAT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LAT_W-1:0] lat_in,
   output logic             busy,
   output logic             finish
);
   logic [LAT_W-1:0] cnt_q;

   assign finish = busy && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         cnt_q <= lat_in;
      end else if (finish) begin
         busy  <= 1'b0;
      end else if (busy) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   a_r5_busy_while_counting: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt_q != '0) |=> busy);
   a_r5_release_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (finish && !start) |=> !busy);
endmodule

// File: rtl/pxu_alu.sv
module pxu_alu
   import pxu_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter bit ROTATE   = 1'b0,
   localparam int SH_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  pxu_op_e           op,
   input  logic [DATA_W-1:0] imm,
   input  logic [DATA_W-1:0] acc,
   output logic [DATA_W-1:0] result
);
   logic [SH_W-1:0]   amount;
   logic [DATA_W-1:0] shifted;

   assign amount = imm[SH_W-1:0];

   generate
      if (ROTATE) begin : g_rotate
         logic [2*DATA_W-1:0] dbl;
         assign dbl     = {acc, acc} << amount;
         assign shifted = dbl[2*DATA_W-1 -: DATA_W];
      end else begin : g_zero_fill
         assign shifted = acc << amount;
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_LOAD: result = imm;
         OP_ADD:  result = acc + imm;
         OP_SHL:  result = shifted;
         OP_XOR:  result = acc ^ imm;
         default: result = acc;
      endcase
   end
endmodule

// File: rtl/prefix_exec_unit.sv
module prefix_exec_unit
   import pxu_pkg::*;
#(
   parameter int          BUS_W   = 16,
   parameter int          ID_LEN  = 2,
   parameter int unsigned ID_CODE = 1,
   parameter int          DATA_W  = 8,
   parameter int          LAT_W   = 4,
   parameter bit          ROTATE  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [BUS_W-1:0]  cmd_data,
   output logic              busy,
   output logic              done_pulse,
   output logic              flag_bit,
   output logic [DATA_W-1:0] acc_out
);
   localparam int CTRL_W  = BUS_W - ID_LEN;
   localparam int IMM_LO  = 0;
   localparam int LAT_LO  = IMM_LO + DATA_W;
   localparam int OP_LO   = LAT_LO + LAT_W;
   localparam int USED_W  = OP_LO + OP_W;

   generate
      if (ID_LEN < 1 || ID_LEN >= BUS_W) begin : g_bad_len
         $error("identifier length must be between 1 and BUS_W-1");
      end
      if (CTRL_W != USED_W) begin : g_bad_fields
         $error("control fields must fill the bits below the identifier");
      end
      if (ID_CODE >= (64'd1 << ID_LEN)) begin : g_bad_code
         $error("identifier code does not fit its length");
      end
   endgenerate

   logic              id_hit;
   logic [CTRL_W-1:0] ctrl_word;
   logic              accept;
   logic              finish;
   pxu_op_e           op_q;
   logic [DATA_W-1:0] imm_q;
   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] acc_next;

   pxu_prefix_match #(.BUS_W(BUS_W), .ID_LEN(ID_LEN), .ID_CODE(ID_CODE)) u_match (
      .cmd_valid (cmd_valid),
      .cmd_data  (cmd_data),
      .id_hit    (id_hit),
      .ctrl_word (ctrl_word)
   );

   assign accept = id_hit && !busy;

   pxu_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .op_in  (pxu_op_e'(ctrl_word[OP_LO +: OP_W])),
      .imm_in (ctrl_word[IMM_LO +: DATA_W]),
      .op_q   (op_q),
      .imm_q  (imm_q)
   );

   pxu_latency_timer #(.LAT_W(LAT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept),
      .lat_in (ctrl_word[LAT_LO +: LAT_W]),
      .busy   (busy),
      .finish (finish)
   );

   pxu_alu #(.DATA_W(DATA_W), .ROTATE(ROTATE)) u_alu (
      .op     (op_q),
      .imm    (imm_q),
      .acc    (acc_q),
      .result (acc_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q      <= '0;
         flag_bit   <= 1'b0;
         done_pulse <= 1'b0;
      end else begin
         done_pulse <= finish;
         if (finish) begin
            acc_q    <= acc_next;
            flag_bit <= 1'b1;
         end else if (accept) begin
            flag_bit <= 1'b0;
         end
      end
   end

   assign acc_out = acc_q;

   a_r3_accept_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (busy && !flag_bit));
   a_r2_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!id_hit && !busy) |=> (!busy && $stable(acc_q) && $stable(flag_bit)));
   a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse);
   a_r6_pulse_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> (flag_bit && !busy));
   a_r7_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(op_q) && $stable(imm_q)));
endmodule

// File: tb/prefix_exec_unit_test.sv
`timescale 1ns/1ps
module prefix_exec_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [15:0] cmd_data = '0;
   logic        busy, done_pulse, flag_bit;
   logic [7:0]  acc_out;

   int vectors = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   prefix_exec_unit uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
      .busy(busy), .done_pulse(done_pulse), .flag_bit(flag_bit), .acc_out(acc_out)
   );

   function automatic logic [15:0] mk(input logic [1:0] id, input logic [1:0] op,
                                      input logic [3:0] lat, input logic [7:0] imm);
      return {id, op, lat, imm};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // R3 R4 R5 R6: one operation, full timeline checked
   task automatic run_op(input logic [1:0] op, input logic [3:0] lat,
                         input logic [7:0] imm, input logic [7:0] exp_acc);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_data  = mk(2'b01, op, lat, imm);
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_data  = '0;
      check("R3 busy after accept", busy, 1);
      check("R3 flag cleared", flag_bit, 0);
      for (int i = 0; i < lat; i++) begin
         @(negedge clk);
         check("R5 busy during latency", busy, 1);
         check("R5 no early done", done_pulse, 0);
      end
      @(negedge clk);
      check("R5 busy falls", busy, 0);
      check("R6 done pulse", done_pulse, 1);
      check("R6 flag set", flag_bit, 1);
      check("R4 result", acc_out, exp_acc);
      @(negedge clk);
      check("R6 pulse one cycle", done_pulse, 0);
      check("R6 flag held", flag_bit, 1);
   endtask

   task automatic t_reset();
      check("R1 busy", busy, 0);
      check("R1 done", done_pulse, 0);
      check("R1 flag", flag_bit, 0);
      check("R1 acc", acc_out, 0);
   endtask

   // R2: foreign identifiers and invalid words are ignored
   task automatic t_foreign(input logic [7:0] held_acc);
      logic [15:0] words [3];
      words[0] = mk(2'b00, 2'd0, 4'd0, 8'h11);
      words[1] = mk(2'b10, 2'd1, 4'd0, 8'h22);
      words[2] = mk(2'b11, 2'd3, 4'd0, 8'h33);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         cmd_valid = 1'b1;
         cmd_data  = words[i];
         @(negedge clk);
         check("R2 foreign not busy", busy, 0);
         check("R2 foreign flag kept", flag_bit, 1);
         check("R2 foreign acc kept", acc_out, held_acc);
      end
      cmd_valid = 1'b0;
      cmd_data  = mk(2'b01, 2'd0, 4'd0, 8'hEE);
      @(negedge clk);
      @(negedge clk);
      check("R2 invalid not busy", busy, 0);
      check("R2 invalid acc kept", acc_out, held_acc);
      cmd_data = '0;
   endtask

   // R7: word held during busy is accepted right after busy falls
   task automatic t_stall();
      int waited;
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_data  = mk(2'b01, 2'd0, 4'd4, 8'h33);
      @(negedge clk);
      cmd_data  = mk(2'b01, 2'd1, 4'd0, 8'h01);
      check("R7 first accepted", busy, 1);
      waited = 0;
      while (done_pulse !== 1'b1 && waited < 20) begin
         @(negedge clk);
         waited++;
         if (done_pulse !== 1'b1) check("R7 busy while held", busy, 1);
      end
      check("R7 first done latency", waited, 5);
      check("R7 refused at finish", busy, 0);
      check("R7 first result", acc_out, 8'h33);
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_data  = '0;
      check("R7 held word taken", busy, 1);
      check("R7 flag cleared", flag_bit, 0);
      check("R7 first result visible", acc_out, 8'h33);
      @(negedge clk);
      check("R7 second done", done_pulse, 1);
      check("R7 second result", acc_out, 8'h34);
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      run_op(2'd0, 4'd0,  8'h5A, 8'h5A);  // R4 load
      run_op(2'd1, 4'd3,  8'hC0, 8'h1A);  // R4 add wraps
      run_op(2'd2, 4'd1,  8'h03, 8'hD0);  // R4 shift zero fill
      run_op(2'd3, 4'd15, 8'hFF, 8'h2F);  // R4 xor, R5 max latency
      t_foreign(8'h2F);
      t_stall();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule